// File: doc/BRIEF.md
# Receive Completion Writeback Batcher

This block sits between a receive datapath and the host memory writer. For each finished frame the datapath hands over one completion record: frame length, checksum, an 8-bit status byte, an 8-bit error byte and a VLAN tag. The block packs these fields into the upper half (bytes 8 to 15) of a 16-byte receive descriptor and holds them in an on-chip queue. The lower half, which carries the buffer address that software placed in the descriptor, is never written.

Queued records are not written one at a time. A programmable threshold, counted either in whole descriptors or in cache lines of several descriptors, decides when enough records have built up. Once it is reached, every pending record is sent in one burst over a request/acknowledge write port, one 64-bit beat per descriptor. Successive beats land 16 bytes apart. A burst that would run past the last slot of the descriptor ring is cut into two bursts, and the second one starts again at the ring base.

Top module: `rxwb_batcher`

## Requirements
- R1: Each data beat carries length in bits 15:0, checksum in bits 31:16, status in bits 39:32, errors in bits 47:40 and VLAN tag in bits 63:48. Status bit 0 (the done flag) is always written as 1 and the other status bits pass through unchanged. Error bits 4 and 3 are always written as 0 and the other error bits pass through unchanged.
- R2: The request address is ring base + 16 × (ring slot of the first record in the burst) + 8, so that only bytes 8 to 15 of a descriptor are written. Each following beat of the same burst belongs to the next ring slot, 16 bytes further on.
- R3: With granularity 1 the effective threshold is the threshold value in descriptors. With granularity 0 it is the threshold value × 4 descriptors (one cache line holds 4 descriptors). No request is made while fewer records are pending. When the threshold is reached, all pending records go out in one burst, subject to R5.
- R4: A threshold value of 0 makes each record be written back on its own, as soon as it is queued.
- R5: A burst never runs past the last ring slot. A group that would cross the end of the ring is issued as two back-to-back bursts, and the second one starts at ring base + 8.
- R6: The queue holds 16 records. The completion ready output is low while the queue is full. A full queue starts a writeback even when the threshold is higher than 16.
- R7: The request holds its address and beat count stable until it is acknowledged. Each beat holds its data until it is accepted with data-ready. The last-beat flag is high only on the final beat of a burst. A request and a data beat are never presented in the same cycle.
- R8: After reset no request and no data beat is presented, completion ready is high, and the first record goes to ring slot 0.
- R9: Records are written in arrival order, each to the next ring slot, and the slot count wraps from the last ring slot back to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ring_base | input | ADDR_W | Byte address of ring slot 0 |
| cfg_wb_thresh | input | THR_W | Writeback threshold value |
| cfg_wb_gran | input | 1 | Threshold unit: 1 = descriptors, 0 = cache lines |
| cmp_valid | input | 1 | Completion record offered |
| cmp_ready | output | 1 | Queue can accept a record |
| cmp_len | input | 16 | Frame length |
| cmp_csum | input | 16 | Frame checksum |
| cmp_stat | input | 8 | Status byte |
| cmp_err | input | 8 | Error byte |
| cmp_vlan | input | 16 | VLAN tag |
| wr_req | output | 1 | Burst write request |
| wr_ack | input | 1 | Request accepted |
| wr_addr | output | ADDR_W | Byte address of the first beat |
| wr_len | output | CNT_W | Beats in the burst |
| wr_dvalid | output | 1 | Data beat valid |
| wr_dready | input | 1 | Data beat accepted |
| wr_data | output | 64 | Upper descriptor half |
| wr_dlast | output | 1 | Final beat of the burst |

## Verification
The assertions check on every cycle the parts of the behaviour that can be seen at the write port alone. These are the handshake holding rules, the last-beat and request/data exclusion rules, the +8 address offset, the forced done flag and reserved error bits, and the rule that no burst runs past the ring end. Other behaviour depends on what came earlier and can only be shown by the bench scenarios. These are when a burst starts in each threshold mode, the immediate writeback for a threshold of 0, the split into two bursts at the ring end, the writeback started by a full queue, the ready output going low at 16 records, and the order and slot in which records land in the model memory.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;

  // Upper descriptor half, least significant field first in memory order
  typedef struct packed {
    logic [15:0] vlan;
    logic [7:0]  err;
    logic [7:0]  stat;
    logic [15:0] csum;
    logic [15:0] len;
  } wb_rec_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DATA = 2'd2
  } wb_state_t;

  localparam logic [7:0] STAT_DONE    = 8'h01;
  localparam logic [7:0] ERR_RSV_MASK = 8'hE7;

  function automatic wb_rec_t pack_rec(input logic [15:0] len,
                                       input logic [15:0] csum,
                                       input logic [7:0]  stat,
                                       input logic [7:0]  err,
                                       input logic [15:0] vlan);
    wb_rec_t r;
    r.len  = len;
    r.csum = csum;
    r.stat = stat | STAT_DONE;
    r.err  = err & ERR_RSV_MASK;
    r.vlan = vlan;
    return r;
  endfunction

endpackage

// File: rtl/rxwb_fifo.sv
module rxwb_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 64,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    wp_d   = push ? wp_q + 1'b1 : wp_q;
    rp_d   = pop  ? rp_q + 1'b1 : rp_q;
    cnt_en = push ^ pop;
    cnt_d  = push ? cnt_q + 1'b1 : cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign dout  = mem[rp_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));

endmodule

// File: rtl/rxwb_trigger.sv
module rxwb_trigger #(
  parameter int THR_W     = 4,
  parameter int LINE_DESC = 4,
  parameter int QDEPTH    = 16,
  localparam int CNT_W    = $clog2(QDEPTH + 1),
  localparam int EW       = THR_W + $clog2(LINE_DESC) + 1,
  localparam int CMPW     = (EW > CNT_W) ? EW : CNT_W
) (
  input  logic [THR_W-1:0] thresh,
  input  logic             gran,
  input  logic [CNT_W-1:0] count,
  output logic             fire
);

  logic [EW-1:0]   eff_raw;
  logic [CMPW-1:0] eff, cnt_x;

  always_comb begin
    eff_raw = gran ? EW'(thresh) : EW'(thresh) * EW'(LINE_DESC);
    eff     = (eff_raw == '0) ? CMPW'(1) : CMPW'(eff_raw);
    cnt_x   = CMPW'(count);
    fire    = (count != '0) &&
              ((cnt_x >= eff) || (count == CNT_W'(QDEPTH)));
  end

endmodule

// File: rtl/rxwb_burst_ctl.sv
module rxwb_burst_ctl
  import rxwb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int RING_DESC = 16,
  parameter int QDEPTH    = 16,
  localparam int CNT_W    = $clog2(QDEPTH + 1),
  localparam int IDX_W    = $clog2(RING_DESC),
  localparam int GAP_W    = IDX_W + 1,
  localparam int LW       = (CNT_W > GAP_W) ? CNT_W : GAP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] base,
  output logic              wr_req,
  input  logic              wr_ack,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [CNT_W-1:0]  wr_len,
  output logic              wr_dvalid,
  input  logic              wr_dready,
  output logic              wr_dlast,
  output logic              pop
);

  wb_state_t       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] grp_q, grp_d, left_q, left_d;
  logic            state_en, idx_en, grp_en, left_en;
  logic [LW-1:0]   to_end, grp_x, seg_len;

  always_comb begin
    to_end  = LW'(RING_DESC) - LW'(idx_q);
    grp_x   = LW'(grp_q);
    seg_len = (grp_x <= to_end) ? grp_x : to_end;
  end

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q + 1'b1;
    grp_d     = grp_q;
    left_d    = left_q;
    state_en  = 1'b0;
    idx_en    = 1'b0;
    grp_en    = 1'b0;
    left_en   = 1'b0;
    wr_req    = 1'b0;
    wr_dvalid = 1'b0;
    wr_dlast  = 1'b0;
    pop       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fire) begin
          grp_d    = count;
          grp_en   = 1'b1;
          state_d  = ST_REQ;
          state_en = 1'b1;
        end
      end
      ST_REQ: begin
        wr_req = 1'b1;
        if (wr_ack) begin
          left_d   = CNT_W'(seg_len);
          left_en  = 1'b1;
          grp_d    = grp_q - CNT_W'(seg_len);
          grp_en   = 1'b1;
          state_d  = ST_DATA;
          state_en = 1'b1;
        end
      end
      ST_DATA: begin
        wr_dvalid = 1'b1;
        wr_dlast  = (left_q == CNT_W'(1));
        if (wr_dready) begin
          pop     = 1'b1;
          idx_en  = 1'b1;
          left_d  = left_q - 1'b1;
          left_en = 1'b1;
          if (left_q == CNT_W'(1)) begin
            state_d  = (grp_q != '0) ? ST_REQ : ST_IDLE;
            state_en = 1'b1;
          end
        end
      end
      default: begin
        state_d  = ST_IDLE;
        state_en = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      grp_q   <= '0;
      left_q  <= '0;
    end else begin
      if (state_en) state_q <= state_d;
      if (idx_en)   idx_q   <= idx_d;
      if (grp_en)   grp_q   <= grp_d;
      if (left_en)  left_q  <= left_d;
    end
  end

  assign wr_addr = base + ADDR_W'({idx_q, 4'h8});
  assign wr_len  = CNT_W'(seg_len);

endmodule

// File: rtl/rxwb_batcher.sv
module rxwb_batcher
  import rxwb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int QDEPTH    = 16,
  parameter int RING_DESC = 16,
  parameter int THR_W     = 4,
  parameter int LINE_DESC = 4,
  localparam int CNT_W    = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_ring_base,
  input  logic [THR_W-1:0]  cfg_wb_thresh,
  input  logic              cfg_wb_gran,
  input  logic              cmp_valid,
  output logic              cmp_ready,
  input  logic [15:0]       cmp_len,
  input  logic [15:0]       cmp_csum,
  input  logic [7:0]        cmp_stat,
  input  logic [7:0]        cmp_err,
  input  logic [15:0]       cmp_vlan,
  output logic              wr_req,
  input  logic              wr_ack,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [CNT_W-1:0]  wr_len,
  output logic              wr_dvalid,
  input  logic              wr_dready,
  output logic [63:0]       wr_data,
  output logic              wr_dlast
);

  wb_rec_t          rec_in;
  logic             push, pop, full, fire;
  logic [CNT_W-1:0] count;
  logic [63:0]      head;

  assign rec_in    = pack_rec(cmp_len, cmp_csum, cmp_stat, cmp_err, cmp_vlan);
  assign cmp_ready = !full;
  assign push      = cmp_valid && !full;

  rxwb_fifo #(.DEPTH(QDEPTH), .W(64)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(rec_in), .pop(pop),
    .dout(head), .count(count), .full(full)
  );

  rxwb_trigger #(.THR_W(THR_W), .LINE_DESC(LINE_DESC), .QDEPTH(QDEPTH)) u_trig (
    .thresh(cfg_wb_thresh), .gran(cfg_wb_gran), .count(count), .fire(fire)
  );

  rxwb_burst_ctl #(.ADDR_W(ADDR_W), .RING_DESC(RING_DESC), .QDEPTH(QDEPTH)) u_ctl (
    .clk(clk), .rst_n(rst_n), .fire(fire), .count(count), .base(cfg_ring_base),
    .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_len(wr_len),
    .wr_dvalid(wr_dvalid), .wr_dready(wr_dready), .wr_dlast(wr_dlast), .pop(pop)
  );

  assign wr_data = head;

endmodule

// File: rtl/rxwb_batcher_chk.sv
module rxwb_batcher_chk #(
  parameter int ADDR_W    = 32,
  parameter int RING_DESC = 16,
  parameter int CNT_W     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_ring_base,
  input logic              wr_req,
  input logic              wr_ack,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CNT_W-1:0]  wr_len,
  input logic              wr_dvalid,
  input logic              wr_dready,
  input logic [63:0]       wr_data,
  input logic              wr_dlast
);

  logic [ADDR_W-1:0] slot_of_req;
  assign slot_of_req = (wr_addr - cfg_ring_base) >> 4;

  // R2: requests only target bytes 8..15 of a descriptor
  p_addr_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wr_addr[3:0] == 4'h8);

  // R7: request held stable until acknowledged
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_len)));

  // R7: beat held stable until accepted
  p_beat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dvalid && !wr_dready) |=> (wr_dvalid && $stable(wr_data) && $stable(wr_dlast)));

  // R7: request and data beat never together
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && wr_dvalid));

  // R1: done flag set and reserved error bits clear on every beat
  p_fields_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dvalid |-> (wr_data[32] && wr_data[44:43] == 2'b00));

  // R5: a burst never runs past the last ring slot
  p_ring_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_len != '0 &&
                slot_of_req + ADDR_W'(wr_len) <= ADDR_W'(RING_DESC)));

endmodule

bind rxwb_batcher rxwb_batcher_chk #(
  .ADDR_W(ADDR_W), .RING_DESC(RING_DESC), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_ring_base(cfg_ring_base),
  .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_len(wr_len),
  .wr_dvalid(wr_dvalid), .wr_dready(wr_dready), .wr_data(wr_data),
  .wr_dlast(wr_dlast)
);

// File: tb/rxwb_batcher_tb.sv
module rxwb_batcher_tb_top;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] BASE       = 32'h0001_0000;
  localparam int          RING       = 16;

  // raw record {vlan, err, stat, csum, len}
  localparam logic [63:0] VEC [8] = '{
    64'h0001_FF_00_1111_0040, 64'h0064_00_FE_2222_05EE,
    64'hFFFF_18_02_3333_0100, 64'h1234_81_80_4444_003C,
    64'h0000_07_41_5555_0800, 64'hA5A5_E7_03_6666_0001,
    64'h5A5A_00_00_7777_FFFF, 64'h0F0F_99_22_8888_0200
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_wb_thresh = '0;
  logic        cfg_wb_gran = 1'b1;
  logic        cmp_valid = 1'b0;
  logic        cmp_ready;
  logic [15:0] cmp_len = '0, cmp_csum = '0, cmp_vlan = '0;
  logic [7:0]  cmp_stat = '0, cmp_err = '0;
  logic        wr_req, wr_dvalid, wr_dlast;
  logic        wr_ack = 1'b0, wr_dready = 1'b0;
  logic [31:0] wr_addr;
  logic [4:0]  wr_len;
  logic [63:0] wr_data;

  int nchk = 0, nbad = 0, nreq = 0, cyc = 0, exp_idx = 0;
  bit ack_en = 1'b1, stall = 1'b0, done = 1'b0;
  logic [31:0] rq_addr [64];
  int          rq_len  [64];
  logic [63:0] hostmem [RING];
  logic [63:0] exp_mem [RING];
  logic [31:0] cur_addr = '0;
  int          cur_left = 0;

  rxwb_batcher dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ring_base(BASE), .cfg_wb_thresh(cfg_wb_thresh),
    .cfg_wb_gran(cfg_wb_gran), .cmp_valid(cmp_valid), .cmp_ready(cmp_ready),
    .cmp_len(cmp_len), .cmp_csum(cmp_csum), .cmp_stat(cmp_stat), .cmp_err(cmp_err),
    .cmp_vlan(cmp_vlan), .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr),
    .wr_len(wr_len), .wr_dvalid(wr_dvalid), .wr_dready(wr_dready),
    .wr_data(wr_data), .wr_dlast(wr_dlast)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  // expected beat from requirement R1
  function automatic logic [63:0] exp_of(input logic [63:0] raw);
    return {raw[63:48], raw[47:40] & 8'hE7, raw[39:32] | 8'h01, raw[31:0]};
  endfunction

  // memory responder: decides ack/ready at negedge for the next posedge
  always @(negedge clk) begin
    if (!rst_n) begin
      wr_ack    = 1'b0;
      wr_dready = 1'b0;
    end else begin
      wr_ack    = ack_en && wr_req;
      wr_dready = stall ? (cyc % 3 != 0) : 1'b1;
      if (wr_ack) begin
        rq_addr[nreq] = wr_addr;
        rq_len[nreq]  = int'(wr_len);
        nreq++;
        cur_addr = wr_addr;
        cur_left = int'(wr_len);
      end
      if (wr_dvalid && wr_dready) begin
        chk(wr_dlast == (cur_left == 1), "R7 last-beat flag",
            64'(wr_dlast), 64'(cur_left == 1));
        hostmem[((cur_addr - BASE) >> 4) % RING] = wr_data;
        cur_addr = cur_addr + 32'd16;
        cur_left--;
      end
    end
  end

  task automatic push_rec(input logic [63:0] raw);
    @(negedge clk);
    {cmp_vlan, cmp_err, cmp_stat, cmp_csum, cmp_len} = raw;
    cmp_valid = 1'b1;
    while (!cmp_ready) @(negedge clk);
    @(negedge clk);
    cmp_valid = 1'b0;
    exp_mem[exp_idx] = exp_of(raw);
    exp_idx = (exp_idx + 1) % RING;
  endtask

  task automatic chk_req(input int n, input logic [31:0] a, input int l, input string req);
    chk(rq_addr[n] == a, req, 64'(rq_addr[n]), 64'(a));
    chk(rq_len[n] == l, req, 64'(rq_len[n]), 64'(l));
  endtask

  task automatic chk_slots(input int first, input int n, input string req);
    for (int k = 0; k < n; k++) begin
      int s = (first + k) % RING;
      chk(hostmem[s] === exp_mem[s], req, hostmem[s], exp_mem[s]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < RING; k++) begin hostmem[k] = '0; exp_mem[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(!wr_req, "R8 no request after reset", 64'(wr_req), 0);
    chk(!wr_dvalid, "R8 no beat after reset", 64'(wr_dvalid), 0);
    chk(cmp_ready, "R8 ready after reset", 64'(cmp_ready), 1);

    // table walk: threshold 4 descriptors (R3, R1, R9), slots 0..7
    cfg_wb_thresh = 4'd4; cfg_wb_gran = 1'b1;
    for (int i = 0; i < 8; i++) begin
      push_rec(VEC[i]);
      if (i == 2) begin
        repeat (5) @(negedge clk);
        chk(nreq == 0, "R3 no burst below threshold", 64'(nreq), 0);
      end
    end
    repeat (20) @(negedge clk);
    chk(nreq == 2, "R3 two bursts of four", 64'(nreq), 2);
    chk_req(0, BASE + 32'd8, 4, "R8 R2 first burst at slot 0");
    chk_req(1, BASE + 32'd72, 4, "R2 second burst at slot 4");
    chk_slots(0, 8, "R1 R9 packed beats in order");

    // R4: threshold 0, slot 8
    cfg_wb_thresh = 4'd0;
    push_rec(64'h7777_10_04_ABCD_0123);
    repeat (10) @(negedge clk);
    chk(nreq == 3, "R4 immediate writeback", 64'(nreq), 3);
    chk_req(2, BASE + 32'd136, 1, "R4 single-beat burst");
    chk_slots(8, 1, "R4 R1 data");

    // threshold 6, slots 9..14
    cfg_wb_thresh = 4'd6;
    for (int i = 0; i < 6; i++) push_rec(VEC[i] ^ 64'h0000_0000_0000_1000);
    repeat (20) @(negedge clk);
    chk(nreq == 4, "R3 burst of six", 64'(nreq), 4);
    chk_req(3, BASE + 32'd152, 6, "R2 burst at slot 9");

    // R5: threshold 4 from slot 15 -> split 1 + 3
    cfg_wb_thresh = 4'd4;
    for (int i = 0; i < 4; i++) push_rec(VEC[7 - i]);
    repeat (20) @(negedge clk);
    chk(nreq == 6, "R5 split into two bursts", 64'(nreq), 6);
    chk_req(4, BASE + 32'd248, 1, "R5 tail burst at last slot");
    chk_req(5, BASE + 32'd8, 3, "R5 wrapped burst at slot 0");
    chk_slots(9, 10, "R9 R5 wrapped data");

    // R3 cache-line units: thresh 1, gran 0 -> 4 descriptors, slots 3..6
    cfg_wb_thresh = 4'd1; cfg_wb_gran = 1'b0;
    for (int i = 0; i < 3; i++) push_rec(VEC[i] ^ 64'h0000_0000_00FF_0000);
    repeat (10) @(negedge clk);
    chk(nreq == 6, "R3 cache-line unit holds three", 64'(nreq), 6);
    push_rec(VEC[3]);
    repeat (15) @(negedge clk);
    chk(nreq == 7, "R3 cache-line unit fires at four", 64'(nreq), 7);
    chk_req(6, BASE + 32'd56, 4, "R3 line burst at slot 3");

    // R6: no acks, threshold 60 > queue; fill 16 records, slots 7..15,0..6
    ack_en = 1'b0; cfg_wb_thresh = 4'd15;
    for (int i = 0; i < 16; i++) push_rec({48'h0, 8'(i), 8'h5A} ^ VEC[i % 8]);
    @(negedge clk);
    chk(!cmp_ready, "R6 ready low when full", 64'(cmp_ready), 0);
    chk(wr_req, "R6 full queue requests writeback", 64'(wr_req), 1);
    // R7 stalled beats
    stall = 1'b1; ack_en = 1'b1;
    repeat (80) @(negedge clk);
    chk(cmp_ready, "R6 ready returns after drain", 64'(cmp_ready), 1);
    chk(nreq == 9, "R6 R5 full group split", 64'(nreq), 9);
    chk_req(7, BASE + 32'd120, 9, "R5 full group first part");
    chk_req(8, BASE + 32'd8, 7, "R5 full group second part");
    chk_slots(0, RING, "R7 R9 data under stalls");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule